// File: doc/BRIEF.md
# Binary FSK Tone Generator with Fractional Baud Strobe

This block produces a frequency-shift-keyed tone as a stream of 8-bit unsigned duty values meant for a downstream PWM stage. A 16-bit phase accumulator advances once per sample tick by one of four fixed tuning words. The word is chosen by the current data bit (mark or space) and by a mode input that selects the answer or the originate frequency pair. The upper six phase bits index a sine lookup that is centred on 128.

A second 16-bit accumulator runs on the same tick and adds a fixed step. Each wrap of this accumulator produces a one-cycle baud strobe. The strobe drives a built-in loop-back pattern generator, which supplies the data bit. The block therefore emits a repeating, self-timed FSK test signal at 300 baud from a 31372.5 Hz tick. The tick itself is an input, so the block runs on any fast clock with a slower enable.

Top module: `fsk_dds_modulator`

## Requirements
- R1: During and right after reset, with no tick yet, sample_o is 128, baud_stb_o is 0 and data_bit_o is 1.
- R2: On each tick, sample_o takes round(128 + 127*sin(2*pi*k/64)) for k equal to phase bits [15:10] as they were before that tick's increment. It shows the new value in the cycle after the tick. The values span 1 (k=48) to 255 (k=16).
- R3: On each tick, the phase advances modulo 2^16. With answer_mode_i=1 it advances by 4230 when data_bit_o=0 (space) and by 4648 when data_bit_o=1 (mark). With answer_mode_i=0 it advances by 2235 for space and 2653 for mark.
- R4: On each tick, the baud accumulator adds 627 modulo 2^16. When the sum wraps, baud_stb_o is 1 for exactly the one cycle after that tick. Otherwise it is 0.
- R5: data_bit_o changes only together with a baud strobe. On successive strobes it takes 1,0,1,1,0,0,1,1,1,0,0,0 and then repeats. The new bit first steers the phase on the tick after the strobe's tick.
- R6: Without a tick, sample_o, data_bit_o and the internal phase hold, and baud_stb_o stays 0.
- R7: A change of answer_mode_i takes effect on the very next tick and keeps phase continuity, with no reset of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle sample-rate enable |
| answer_mode_i | input | 1 | 1 selects the answer tone pair, 0 the originate pair |
| sample_o | output | 8 | Unsigned sine duty sample |
| baud_stb_o | output | 1 | One-cycle baud strobe |
| data_bit_o | output | 1 | Current loop-back data bit (1 mark, 0 space) |

## Verification
The assertions assume that tick_i is a clean synchronous enable. They also assume the baud step is far below half the accumulator range, so two consecutive ticks can never both wrap, and the single-cycle strobe check relies on that. tick_i and answer_mode_i are changed only at falling edges. Tick spacing varies from back-to-back to three idle cycles, which covers both the case where the strobe overlaps the next tick and the case where it does not. The mode is switched in long blocks and also on every tick for a short stretch, so each stimulus stays inside what the assertions assume while still reaching every tone word.

// File: rtl/fsk_pkg.sv
`timescale 1ns/1ps
package fsk_pkg;
  localparam int PHASE_W  = 16;
  localparam int LUT_AW   = 6;
  localparam int SAMPLE_W = 8;
  localparam int BAUD_W   = 16;
  localparam int PAT_LEN  = 12;

  localparam logic [BAUD_W-1:0] BAUD_INC = 16'd627;

  typedef struct packed {
    logic [PHASE_W-1:0] space;
    logic [PHASE_W-1:0] mark;
  } tone_pair_t;

  localparam tone_pair_t ANS_TONES = '{space: 16'd4230, mark: 16'd4648};
  localparam tone_pair_t ORG_TONES = '{space: 16'd2235, mark: 16'd2653};

  // bit 0 is sent first
  localparam logic [PAT_LEN-1:0] LOOP_SEQ = 12'b0001_1100_1101;

  function automatic logic [PHASE_W-1:0] tone_word(input logic answer, input logic mark);
    tone_pair_t p;
    p = answer ? ANS_TONES : ORG_TONES;
    return mark ? p.mark : p.space;
  endfunction
endpackage

// File: rtl/fsk_accum.sv
`timescale 1ns/1ps
module fsk_accum #(
  parameter int W     = 16,
  parameter int OUT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     inc_i,
  output logic [OUT_W-1:0] acc_o,
  output logic             wrap_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign wrap_o = sum[W];
  assign acc_o  = acc_q[W-1 -: OUT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum[W-1:0];
  end

  assert_acc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));

  assert_wrap_below_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap_o) |=> (acc_q < $past(inc_i)));
endmodule

// File: rtl/fsk_sine_rom.sv
`timescale 1ns/1ps
module fsk_sine_rom
  import fsk_pkg::*;
(
  input  logic [LUT_AW-1:0]   idx_i,
  output logic [SAMPLE_W-1:0] val_o
);
  logic [4:0]          qk;
  logic [SAMPLE_W-1:0] qv;

  // quarter-wave fold: 17 stored points cover all 64 indices
  function automatic logic [SAMPLE_W-1:0] quarter(input logic [4:0] k);
    case (k)
      5'd0:  return 8'd128;
      5'd1:  return 8'd140;
      5'd2:  return 8'd153;
      5'd3:  return 8'd165;
      5'd4:  return 8'd177;
      5'd5:  return 8'd188;
      5'd6:  return 8'd199;
      5'd7:  return 8'd209;
      5'd8:  return 8'd218;
      5'd9:  return 8'd226;
      5'd10: return 8'd234;
      5'd11: return 8'd240;
      5'd12: return 8'd245;
      5'd13: return 8'd250;
      5'd14: return 8'd253;
      5'd15: return 8'd254;
      5'd16: return 8'd255;
      default: return 8'd128;
    endcase
  endfunction

  assign qk    = idx_i[4] ? (5'd16 - {1'b0, idx_i[3:0]}) : {1'b0, idx_i[3:0]};
  assign qv    = quarter(qk);
  assign val_o = idx_i[5] ? (~qv + 8'd1) : qv;
endmodule

// File: rtl/fsk_bit_pattern.sv
`timescale 1ns/1ps
module fsk_bit_pattern #(
  parameter int             LEN = 12,
  parameter logic [LEN-1:0] SEQ = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic bit_o
);
  localparam int IW = $clog2(LEN);

  logic [IW-1:0] idx_q;
  logic          bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      bit_q <= 1'b1;
    end else if (adv_i) begin
      bit_q <= SEQ[idx_q];
      idx_q <= (idx_q == IW'(LEN - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign bit_o = bit_q;

  assert_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < LEN);

  assert_bit_only_on_adv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_q) |-> $past(adv_i));
endmodule

// File: rtl/fsk_dds_modulator.sv
`timescale 1ns/1ps
module fsk_dds_modulator
  import fsk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                answer_mode_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                baud_stb_o,
  output logic                data_bit_o
);
  logic [PHASE_W-1:0]  word;
  logic [LUT_AW-1:0]   lut_idx;
  logic [SAMPLE_W-1:0] lut_val;
  logic                phase_wrap;
  logic                baud_wrap;
  logic                baud_msb;
  logic                baud_hit;
  logic [SAMPLE_W-1:0] sample_q;
  logic                stb_q;

  assign word     = tone_word(answer_mode_i, data_bit_o);
  assign baud_hit = tick_i & baud_wrap;

  fsk_accum #(.W(PHASE_W), .OUT_W(LUT_AW)) u_phase (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (tick_i),
    .inc_i (word), .acc_o (lut_idx), .wrap_o (phase_wrap)
  );

  fsk_accum #(.W(BAUD_W), .OUT_W(1)) u_baud (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (tick_i),
    .inc_i (BAUD_INC), .acc_o (baud_msb), .wrap_o (baud_wrap)
  );

  fsk_sine_rom u_rom (.idx_i (lut_idx), .val_o (lut_val));

  fsk_bit_pattern #(.LEN(PAT_LEN), .SEQ(LOOP_SEQ)) u_pat (
    .clk_i (clk_i), .rst_ni (rst_ni), .adv_i (baud_hit), .bit_o (data_bit_o)
  );

  // sample uses phase before this tick's increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 8'd128;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= baud_hit;
      if (tick_i) sample_q <= lut_val;
    end
  end

  assign sample_o   = sample_q;
  assign baud_stb_o = stb_q;

  assert_stb_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_stb_o |=> !baud_stb_o);

  assert_stb_after_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_stb_o |-> !baud_msb);

  assert_data_with_stb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_bit_o) |-> baud_stb_o);

  assert_hold_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(sample_o) && !baud_stb_o));

  assert_sample_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != '0);

  assert_phase_wrap_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_wrap && !tick_i) |=> $stable(sample_o));
endmodule

// File: tb/fsk_dds_modulator_tb_top.sv
`timescale 1ns/1ps
module fsk_dds_modulator_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       answer_mode_i = 1'b0;
  logic [7:0] sample_o;
  logic       baud_stb_o;
  logic       data_bit_o;

  always #4 clk = ~clk;

  fsk_dds_modulator dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .tick_i (tick_i), .answer_mode_i (answer_mode_i),
    .sample_o (sample_o), .baud_stb_o (baud_stb_o), .data_bit_o (data_bit_o)
  );

  typedef struct {
    int    smp;
    bit    stb;
    bit    dat;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   started = 0;
  bit   pend = 0;
  int   last_smp = 128;
  bit   last_dat = 1;

  int sine_tab[64];
  bit pat[12] = '{1, 0, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0};
  int m_phase = 0;
  int m_baud = 0;
  int m_pidx = 0;
  bit m_data = 1;
  bit m_mode = 0;
  int since_mode = 100;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // driver: called at a falling edge, leaves on a falling edge
  task automatic drive_tick(bit mode, int gap);
    exp_t e;
    int   word;
    int   nb;
    if (mode != m_mode) since_mode = 0;
    else since_mode++;
    m_mode = mode;
    answer_mode_i = mode;
    tick_i = 1'b1;
    e.smp = sine_tab[m_phase >> 10];
    e.req = (since_mode < 3) ? "R7" : "R2/R3";
    // R3 tone words
    if (mode) word = m_data ? 4648 : 4230;
    else      word = m_data ? 2653 : 2235;
    m_phase = (m_phase + word) % 65536;
    nb = m_baud + 627;
    e.stb = (nb >= 65536);
    m_baud = nb % 65536;
    if (e.stb) begin
      m_data = pat[m_pidx];
      m_pidx = (m_pidx + 1) % 12;
    end
    e.dat = m_data;
    q.push_back(e);
    @(negedge clk);
    tick_i = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  always @(posedge clk) pend <= tick_i;

  // monitor
  always @(negedge clk) begin
    if (started) begin
      if (pend) begin
        if (q.size() == 0) begin
          chk("R4", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.req, "sample_o", int'(sample_o), e.smp);
          chk("R4", "baud_stb_o", int'(baud_stb_o), int'(e.stb));
          chk("R5", "data_bit_o", int'(data_bit_o), int'(e.dat));
        end
        last_smp = int'(sample_o);
        last_dat = data_bit_o;
      end else begin
        chk("R6", "idle baud_stb_o", int'(baud_stb_o), 0);
        chk("R6", "idle sample_o", int'(sample_o), last_smp);
        chk("R6", "idle data_bit_o", int'(data_bit_o), int'(last_dat));
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++)
      sine_tab[k] = $rtoi(128.0 + 127.0 * $sin(2.0 * 3.14159265358979 * k / 64.0) + 0.5);
    // R2 extremes of the table itself
    chk("R2", "table peak", sine_tab[16], 255);
    chk("R2", "table trough", sine_tab[48], 1);

    repeat (3) @(negedge clk);
    chk("R1", "reset sample_o", int'(sample_o), 128);
    chk("R1", "reset baud_stb_o", int'(baud_stb_o), 0);
    chk("R1", "reset data_bit_o", int'(data_bit_o), 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "post-reset sample_o", int'(sample_o), 128);
    chk("R1", "post-reset baud_stb_o", int'(baud_stb_o), 0);
    chk("R1", "post-reset data_bit_o", int'(data_bit_o), 1);
    started = 1;

    for (int t = 0; t < 3000; t++) begin
      bit md;
      if (t < 1000)      md = 1'b0;
      else if (t < 2000) md = 1'b1;
      else if (t < 2040) md = t[0];   // R7: flip every tick
      else               md = 1'b0;
      drive_tick(md, t % 4);
    end
    repeat (4) @(negedge clk);
    chk("R4", "queue drained", q.size(), 0);
    summary();
    $finish;
  end
endmodule